// File: doc/BRIEF.md
# Bidirectional Mode-Selectable Timer Counter

This block is the counting core of an 8-bit timer. A prescaler outside the block delivers a one-cycle tick enable, and a 3-bit source-select field either lets those ticks through or, at value zero, stops the timer. On each accepted tick the count clears, steps up or steps down by one, following one of four sequences chosen by a 2-bit mode field. Two comparators flag the count at its all-ones maximum and at zero.

An overflow flag is raised by the mode's own rule. It stays set until the host writes a one to clear it, and it raises an interrupt request while an enable bit is set. The host can load the count at any time, including while the timer is stopped, and reads it on `cnt_o`. A host load in a cycle always beats a tick in that same cycle.

Top module: `tmr_core`

## Requirements
- R1: After reset the count is 0, the count direction is up, the overflow flag is 0 and `irq_o` is 0.
- R2: The count changes on a tick only when `tick_i` is 1 and `src_sel_i` is nonzero. With `src_sel_i` = 0 or `tick_i` = 0 the count holds.
- R3: A host load (`cnt_we_i` = 1) puts `cnt_wdata_i` into the count at the next edge. It takes priority over any tick in the same cycle.
- R4: In mode 0 and in mode 3 each tick adds one. A tick at 255 wraps the count to 0 and sets the overflow flag.
- R5: Mode 1 counts up and down.
  - A tick while counting up at 255 gives 254 and turns the direction to down.
  - A tick while counting down at 0 gives 1 and turns the direction to up.
  - The flag is set by the tick that moves the count from 1 to 0.
- R6: In mode 2 a tick while the count equals `cmp_i` gives 0. Any other tick adds one, with 255 wrapping to 0. The flag is set only by a tick taken at 255, including the case where `cmp_i` is 255.
- R7: `top_o` is 1 exactly when the count is 255. `bottom_o` is 1 exactly when the count is 0.
- R8: The overflow flag holds until `ovf_clr_i` is 1. When a set event and a clear fall in the same cycle, the set wins.
- R9: `irq_o` equals the overflow flag ANDed with `irq_en_i`.
- R10: A cycle with a host load never sets the overflow flag, even if a tick at 255 arrives in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Tick enable from the prescaler |
| src_sel_i | input | 3 | Tick source select; 0 stops the timer |
| mode_i | input | 2 | Count sequence: 0 wrap, 1 up/down, 2 clear on compare, 3 wrap |
| cmp_i | input | 8 | Compare value for mode 2 |
| cnt_we_i | input | 1 | Host load strobe for the count |
| cnt_wdata_i | input | 8 | Host load data |
| ovf_clr_i | input | 1 | Host write-one-to-clear of the overflow flag |
| irq_en_i | input | 1 | Interrupt enable |
| cnt_o | output | 8 | Current count |
| top_o | output | 1 | Count at maximum |
| bottom_o | output | 1 | Count at zero |
| ovf_o | output | 1 | Overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of events can collide in one cycle.

The first pair is a host load and an active tick. The bench holds `tick_i` high with a nonzero source select and pulses `cnt_we_i`, once at an ordinary count and once at 255. It then judges that the count equals the loaded value and that the flag stayed clear.

The second pair is a flag clear and a flag-setting tick. The bench drives `ovf_clr_i` in the same cycle as a wrap tick and expects the flag to read as set afterwards.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_WRAP   = 2'd0,
    MODE_UPDOWN = 2'd1,
    MODE_CMP    = 2'd2,
    MODE_WRAP3  = 2'd3
  } tmr_mode_e;
endpackage

// File: rtl/tmr_cnt.sv
module tmr_cnt
  import tmr_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  tmr_mode_e     mode_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_evt_o
);
  localparam logic [CW-1:0] MAX = {CW{1'b1}};
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic          ovf;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = (mode_i == MODE_UPDOWN) ? up_q : 1'b1;
    ovf   = 1'b0;
    if (step_i) begin
      unique case (mode_i)
        MODE_UPDOWN: begin
          if (up_q) begin
            if (cnt_q == MAX) begin
              cnt_d = MAX - ONE;
              up_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_d = ONE;
              up_d  = 1'b1;
            end else begin
              cnt_d = cnt_q - ONE;
            end
            ovf = (cnt_q == ONE);
          end
        end
        MODE_CMP: begin
          ovf   = (cnt_q == MAX);
          cnt_d = (cnt_q == cmp_i) ? '0 : cnt_q + ONE;
        end
        default: begin
          ovf   = (cnt_q == MAX);
          cnt_d = cnt_q + ONE;
        end
      endcase
    end
    // host load overrides any tick action
    if (we_i) begin
      cnt_d = wdata_i;
      up_d  = (mode_i == MODE_UPDOWN) ? up_q : 1'b1;
      ovf   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o     = cnt_q;
  assign ovf_evt_o = ovf;

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> cnt_q == $past(wdata_i)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !we_i && mode_i != MODE_UPDOWN && cnt_q == MAX |=> cnt_q == '0); // R4
  AST_UD_TURN_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !we_i && mode_i == MODE_UPDOWN && up_q && cnt_q == MAX |=> cnt_q == MAX - ONE); // R5
  AST_UD_TURN_BOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !we_i && mode_i == MODE_UPDOWN && !up_q && cnt_q == '0 |=> cnt_q == ONE); // R5
  AST_CMP_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !we_i && mode_i == MODE_CMP && cnt_q == cmp_i |=> cnt_q == '0); // R6
endmodule

// File: rtl/tmr_limits.sv
module tmr_limits #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  output logic          top_o,
  output logic          bottom_o
);
  assign top_o    = &cnt_i;
  assign bottom_o = ~|cnt_i;

  AST_LIMITS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(top_o && bottom_o)); // R7
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // set beats clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (set_i)   flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !clr_i |=> flag_q); // R8
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q); // R8
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CW = 8,
  parameter int SW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [SW-1:0] src_sel_i,
  input  logic [1:0]    mode_i,
  input  logic [CW-1:0] cmp_i,
  input  logic          cnt_we_i,
  input  logic [CW-1:0] cnt_wdata_i,
  input  logic          ovf_clr_i,
  input  logic          irq_en_i,
  output logic [CW-1:0] cnt_o,
  output logic          top_o,
  output logic          bottom_o,
  output logic          ovf_o,
  output logic          irq_o
);
  logic step, ovf_evt;

  assign step = tick_i && (src_sel_i != '0);

  tmr_cnt #(.CW(CW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .mode_i    (tmr_mode_e'(mode_i)),
    .cmp_i     (cmp_i),
    .we_i      (cnt_we_i),
    .wdata_i   (cnt_wdata_i),
    .cnt_o     (cnt_o),
    .ovf_evt_o (ovf_evt)
  );

  tmr_limits #(.CW(CW)) u_lim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cnt_i    (cnt_o),
    .top_o    (top_o),
    .bottom_o (bottom_o)
  );

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf_evt),
    .clr_i  (ovf_clr_i),
    .en_i   (irq_en_i),
    .flag_o (ovf_o),
    .irq_o  (irq_o)
  );

  AST_STOPPED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_we_i && src_sel_i == '0 |=> $stable(cnt_o)); // R2
  AST_WRITE_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_i && !ovf_o |=> !ovf_o); // R10
endmodule

// File: tb/tb_tmr_core.sv
module tb_tmr_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] src = 3'd0;
  logic [1:0] mode = 2'd0;
  logic [7:0] cmp = 8'd0;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic       clr = 1'b0;
  logic       ien = 1'b0;
  logic [7:0] cnt;
  logic       top, bot, ovf, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_core dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .src_sel_i(src), .mode_i(mode),
    .cmp_i(cmp), .cnt_we_i(we), .cnt_wdata_i(wdata), .ovf_clr_i(clr),
    .irq_en_i(ien), .cnt_o(cnt), .top_o(top), .bottom_o(bot), .ovf_o(ovf), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [7:0] v);
    we = 1'b1; wdata = v; step(); we = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin tick = 1'b1; step(); end
    tick = 1'b0;
  endtask

  task automatic clear_flag();
    clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cnt", cnt, 0); chk("R1 ovf", ovf, 0); chk("R1 irq", irq, 0);
    chk("R7 bottom", bot, 1); chk("R7 top", top, 0);
  endtask

  task automatic t_stopped();
    src = 3'd0; ticks(5); chk("R2 stopped", cnt, 0);
    src = 3'd4; tick = 1'b0; step(); step(); chk("R2 no tick", cnt, 0);
    load(8'd77); chk("R3 load while stopped", cnt, 77);
    src = 3'd0; load(8'd9); chk("R3 load src0", cnt, 9);
    src = 3'd1; ticks(1); chk("R2 running", cnt, 10);
  endtask

  task automatic t_wrap(input logic [1:0] m);
    mode = m; src = 3'd1; load(8'd250);
    ticks(5); chk("R4 at 255", cnt, 255); chk("R7 top", top, 1); chk("R4 no flag yet", ovf, 0);
    ticks(1); chk("R4 wrap", cnt, 0); chk("R4 flag", ovf, 1); chk("R7 bottom", bot, 1);
    ien = 1'b0; #1 chk("R9 masked", irq, 0);
    ien = 1'b1; #1 chk("R9 irq", irq, 1);
    ticks(3); chk("R8 sticky", ovf, 1);
    clear_flag(); chk("R8 cleared", ovf, 0); chk("R9 irq off", irq, 0);
    ien = 1'b0;
  endtask

  task automatic t_priority();
    mode = 2'd0; src = 3'd2; load(8'd40);
    tick = 1'b1; we = 1'b1; wdata = 8'd10; step(); we = 1'b0; tick = 1'b0;
    chk("R3 write beats tick", cnt, 10);
    load(8'd255);
    tick = 1'b1; we = 1'b1; wdata = 8'd5; step(); we = 1'b0; tick = 1'b0;
    chk("R3 write at 255", cnt, 5); chk("R10 no flag on write", ovf, 0);
  endtask

  task automatic t_updown();
    mode = 2'd1; src = 3'd1; load(8'd253);
    ticks(1); chk("R5 up", cnt, 254);
    ticks(1); chk("R5 reach top", cnt, 255);
    ticks(1); chk("R5 turn at top", cnt, 254);
    ticks(1); chk("R5 down", cnt, 253); chk("R5 no flag", ovf, 0);
    load(8'd2); ticks(1); chk("R5 keep down after load", cnt, 1);
    ticks(1); chk("R5 reach bottom", cnt, 0); chk("R5 flag at bottom", ovf, 1);
    ticks(1); chk("R5 turn at bottom", cnt, 1);
    ticks(1); chk("R5 up again", cnt, 2);
    clear_flag();
  endtask

  task automatic t_cmp();
    mode = 2'd2; src = 3'd3; cmp = 8'd5; load(8'd3);
    ticks(2); chk("R6 reach cmp", cnt, 5);
    ticks(1); chk("R6 clear at cmp", cnt, 0); chk("R6 no flag on cmp clear", ovf, 0);
    cmp = 8'd10; load(8'd254);
    ticks(1); chk("R6 above cmp", cnt, 255);
    ticks(1); chk("R6 wrap", cnt, 0); chk("R6 flag on wrap", ovf, 1);
    clear_flag(); cmp = 8'd255; load(8'd254);
    ticks(2); chk("R6 cmp at max", cnt, 0); chk("R6 flag cmp max", ovf, 1);
    clear_flag();
  endtask

  task automatic t_set_wins();
    mode = 2'd0; src = 3'd1; load(8'd255);
    tick = 1'b1; clr = 1'b1; step(); tick = 1'b0; clr = 1'b0;
    chk("R8 set beats clear", ovf, 1); chk("R4 wrap", cnt, 0);
    clear_flag(); chk("R8 clear", ovf, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1'b1; step();
    t_reset();
    t_stopped();
    t_wrap(2'd0);
    t_wrap(2'd3);
    t_priority();
    t_updown();
    t_cmp();
    t_set_wins();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule